// File: doc/BRIEF.md
# Multi-Mode 12-bit Timer/Counter

This block is a general-purpose timer for a small microcontroller. One up-counting 12-bit register serves four jobs. It can time a fixed interval, count edges on an external pin, measure how long that pin stays high, or produce a square wave on an output pin. A 12-bit free-running prescaler paces the counter in the timed modes. The prescaler sets the counting rate through a divide select of 2^n, where n runs from 0 to 12.

The external pin passes through a two-flop synchroniser and then a level qualifier. Only a level that holds for two full cycles counts as an edge. The same qualified signal feeds event counting and pulse-width measurement. Each time the counter rolls over from its all-ones value, it raises a one-cycle overflow interrupt request. Software writes a mode/divider word and a 12-bit reload word. Writing the mode word restarts the counter from the reload word.

After reset, and after a wake from the low-power hold state, the counter starts at 0xFFC. With the fastest divider, the first overflow therefore comes four ticks later.

Top module: `tmr12_multi`

## Requirements
- R1: While reset is high and on the first cycle after it, the count reads 0xFFC and both the square output and the interrupt are low. Reset selects interval mode with divider 0 (one tick per clock).
- R2: A divider value n gives one tick every 2^n clocks, and values above 12 behave as 12. A control write clears the prescaler and loads the count from the reload register. A reload write on its own leaves the running count untouched.
- R3: A count step from 0xFFF raises the interrupt output for the single following cycle. The interrupt is low in every other cycle.
- R4: Interval mode (mode code 0) adds one per tick and wraps from 0xFFF to 0x000.
- R5: Event mode (mode code 1) adds one per qualified rising edge of the pin, whatever the divider setting.
- R6: After synchronisation, a pin level must be seen for two consecutive cycles before it is accepted. A one-cycle pulse has no effect.
- R7: Pulse-width mode (mode code 2) adds one per tick while the qualified pin is high. On the first qualified falling edge the count freezes, and it stays frozen until the next control write.
- R8: Square-wave mode (mode code 3) reloads the count from the reload register on each overflow and toggles the square output. A control write drives the square output low.
- R9: A wake pulse sets the count to 0xFFC and clears the prescaler. It keeps the mode, the reload value and the square output level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 1 | One-cycle pulse on exit from the hold state |
| ctl_we_i | input | 1 | Write strobe for mode and divider; restarts the count |
| ctl_mode_i | input | 2 | Mode code: 0 interval, 1 event, 2 pulse width, 3 square |
| ctl_div_i | input | 4 | Prescaler divide select n (tick every 2^n clocks) |
| reload_we_i | input | 1 | Write strobe for the reload register |
| reload_i | input | 12 | Reload value |
| pin_i | input | 1 | Asynchronous external event / gate pin |
| count_o | output | 12 | Current count readback |
| sq_o | output | 1 | Square-wave output |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench uses the default parameters: a 12-bit counter, a 12-bit prescaler, two synchroniser stages and a two-cycle qualification window. Because the prescaler is only 12 bits, the clamped divide of 4096 fits within the run, so the clamp and the exact tick boundary can both be tested. The 0xFFC restore value means every reset or wake reaches an overflow within a few cycles. Because the qualification window is two cycles, both an accepted pulse and a rejected one-cycle glitch can be placed cycle-exactly.

// File: rtl/tmr12_pkg.sv
package tmr12_pkg;

    parameter int           TMR_CNT_W   = 12;
    parameter int           TMR_PRE_W   = 12;
    parameter logic [11:0]  TMR_RESTORE = 12'hFFC;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'd0,
        MODE_EVENT    = 2'd1,
        MODE_PWIDTH   = 2'd2,
        MODE_SQUARE   = 2'd3
    } tmr_mode_e;

    // per-cycle timing events delivered to the counter core
    typedef struct packed {
        logic tick;   // prescaler tick
        logic lvl;    // qualified pin level
        logic rise;   // qualified rising edge
        logic fall;   // qualified falling edge
    } tmr_evt_t;

    function automatic logic mode_steps(tmr_mode_e m, tmr_evt_t e, logic frozen);
        case (m)
            MODE_INTERVAL: return e.tick;
            MODE_EVENT:    return e.rise;
            MODE_PWIDTH:   return e.tick & e.lvl & ~frozen;
            default:       return e.tick;
        endcase
    endfunction

endpackage

// File: rtl/tmr12_prescaler.sv
module tmr12_prescaler #(
    parameter int PRE_W = 12,
    localparam int SEL_W = $clog2(PRE_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] mask;
    logic [SEL_W-1:0] sel_c;

    always_comb begin
        sel_c = (sel_i > SEL_W'(PRE_W)) ? SEL_W'(PRE_W) : sel_i;
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(sel_c));
        end
    end

    assign tick_o = ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    // a divide of 2^n must never tick in two adjacent cycles for n >= 1
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (tick_o && sel_c != '0 && !clr_i) |=> !tick_o)
        else $error("prescaler ticked twice in a row"); // R2

endmodule

// File: rtl/tmr12_pin_qual.sv
module tmr12_pin_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYC    = 2,
    localparam int QW = (QUAL_CYC < 2) ? 1 : $clog2(QUAL_CYC)
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   s;
    logic [QW-1:0]          qcnt_q;
    logic                   lvl_q;
    logic                   lvl_d_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            qcnt_q  <= '0;
            lvl_q   <= 1'b0;
            lvl_d_q <= 1'b0;
        end else begin
            lvl_d_q <= lvl_q;
            if (s == lvl_q) begin
                qcnt_q <= '0;
            end else if (qcnt_q == QW'(QUAL_CYC - 1)) begin
                qcnt_q <= '0;
                lvl_q  <= s;
            end else begin
                qcnt_q <= qcnt_q + 1'b1;
            end
        end
    end

    assign lvl_o  = lvl_q;
    assign rise_o = lvl_q & ~lvl_d_q;
    assign fall_o = ~lvl_q & lvl_d_q;

    AST_QUAL_NEEDS_DIFF: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl_q) |-> ($past(s) != $past(lvl_q)))
        else $error("qualified level moved without differing input"); // R6

endmodule

// File: rtl/tmr12_core.sv
module tmr12_core
    import tmr12_pkg::*;
#(
    parameter int               CNT_W       = 12,
    parameter logic [CNT_W-1:0] RESTORE_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake_i,
    input  logic             load_i,
    input  tmr_mode_e        mode_i,
    input  logic [CNT_W-1:0] reload_i,
    input  tmr_evt_t         ev_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sq_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;
    logic             sq_q;
    logic             irq_q;
    logic             frozen_q;
    logic             step;
    logic             roll;

    assign step = mode_steps(mode_i, ev_i, frozen_q);
    assign roll = step && (count_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= RESTORE_VAL;
            sq_q     <= 1'b0;
            irq_q    <= 1'b0;
            frozen_q <= 1'b0;
        end else if (wake_i) begin
            count_q  <= RESTORE_VAL;
            irq_q    <= 1'b0;
            frozen_q <= 1'b0;
        end else if (load_i) begin
            count_q  <= reload_i;
            sq_q     <= 1'b0;
            irq_q    <= 1'b0;
            frozen_q <= 1'b0;
        end else begin
            irq_q <= roll;
            if (step) begin
                if (roll && mode_i == MODE_SQUARE) count_q <= reload_i;
                else                               count_q <= count_q + 1'b1;
            end
            if (roll && mode_i == MODE_SQUARE) sq_q <= ~sq_q;
            if (mode_i == MODE_PWIDTH && ev_i.fall) frozen_q <= 1'b1;
        end
    end

    assign count_o = count_q;
    assign sq_o    = sq_q;
    assign irq_o   = irq_q;

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count_q == RESTORE_VAL && !sq_q && !irq_q))
        else $error("bad post-reset state"); // R1

    AST_OVF_FROM_MAX: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(count_q) == CNT_MAX))
        else $error("interrupt without a roll from max"); // R3

    AST_WAKE_RESTORE: assert property (@(posedge clk) disable iff (rst)
        wake_i |=> (count_q == RESTORE_VAL))
        else $error("wake did not restore the count"); // R9

    AST_EVT_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_EVENT && !load_i && !wake_i)
            |=> (CNT_W'(count_q - $past(count_q)) <= CNT_W'(1)))
        else $error("event mode jumped by more than one"); // R5

    AST_PW_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && mode_i == MODE_PWIDTH && !load_i && !wake_i) |=> $stable(count_q))
        else $error("frozen pulse width moved"); // R7

    AST_SQ_ONLY_ON_OVF: assert property (@(posedge clk) disable iff (rst)
        !$stable(sq_q) |-> (irq_q || $past(load_i)))
        else $error("square output moved without overflow or write"); // R8

endmodule

// File: rtl/tmr12_multi.sv
module tmr12_multi
    import tmr12_pkg::*;
#(
    parameter int CNT_W       = TMR_CNT_W,
    parameter int PRE_W       = TMR_PRE_W,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYC    = 2,
    localparam int SEL_W      = $clog2(PRE_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake_i,
    input  logic             ctl_we_i,
    input  logic [1:0]       ctl_mode_i,
    input  logic [SEL_W-1:0] ctl_div_i,
    input  logic             reload_we_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             pin_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sq_o,
    output logic             irq_o
);

    tmr_mode_e        mode_q;
    logic [SEL_W-1:0] div_q;
    logic [CNT_W-1:0] reload_q;
    tmr_evt_t         ev;
    logic             tick;
    logic             lvl;
    logic             rise;
    logic             fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_INTERVAL;
            div_q    <= '0;
            reload_q <= '0;
        end else begin
            if (ctl_we_i) begin
                mode_q <= tmr_mode_e'(ctl_mode_i);
                div_q  <= ctl_div_i;
            end
            if (reload_we_i) reload_q <= reload_i;
        end
    end

    tmr12_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (ctl_we_i | wake_i),
        .sel_i  (div_q),
        .tick_o (tick)
    );

    tmr12_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYC(QUAL_CYC)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    always_comb begin
        ev.tick = tick;
        ev.lvl  = lvl;
        ev.rise = rise;
        ev.fall = fall;
    end

    tmr12_core #(
        .CNT_W       (CNT_W),
        .RESTORE_VAL (CNT_W'(TMR_RESTORE))
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .wake_i   (wake_i),
        .load_i   (ctl_we_i),
        .mode_i   (mode_q),
        .reload_i (reload_q),
        .ev_i     (ev),
        .count_o  (count_o),
        .sq_o     (sq_o),
        .irq_o    (irq_o)
    );

    AST_IRQ_NOT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ctl_we_i || wake_i) |=> !irq_o)
        else $error("interrupt after a write or wake"); // R3

endmodule

// File: tb/tmr12_multi_tb.sv
module tmr12_multi_tb;

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  div;
        logic [11:0] reload;
        logic [15:0] ncyc;
        logic [11:0] exp_cnt;
        logic        exp_sq;
    } vec_t;

    // mode codes: 0 interval, 1 event, 2 pulse width, 3 square
    localparam vec_t VECS [8] = '{
        '{2'd0, 4'd0, 12'h100, 16'd10, 12'h10A, 1'b0},  // R4 R2
        '{2'd0, 4'd2, 12'h020, 16'd16, 12'h024, 1'b0},  // R2
        '{2'd0, 4'd3, 12'hFFE, 16'd16, 12'h000, 1'b0},  // R4 wrap
        '{2'd0, 4'd1, 12'h7F0, 16'd7,  12'h7F3, 1'b0},  // R2
        '{2'd3, 4'd0, 12'hFFA, 16'd6,  12'hFFA, 1'b1},  // R8
        '{2'd3, 4'd0, 12'hFF0, 16'd40, 12'hFF8, 1'b0},  // R8
        '{2'd3, 4'd1, 12'hFFC, 16'd13, 12'hFFE, 1'b1},  // R8
        '{2'd1, 4'd0, 12'h055, 16'd20, 12'h055, 1'b0}   // R5 idle pin
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wake_i = 1'b0;
    logic        ctl_we_i = 1'b0;
    logic [1:0]  ctl_mode_i = '0;
    logic [3:0]  ctl_div_i = '0;
    logic        reload_we_i = 1'b0;
    logic [11:0] reload_i = '0;
    logic        pin_i = 1'b0;
    logic [11:0] count_o;
    logic        sq_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tmr12_multi u_dut (
        .clk         (clk),
        .rst         (rst),
        .wake_i      (wake_i),
        .ctl_we_i    (ctl_we_i),
        .ctl_mode_i  (ctl_mode_i),
        .ctl_div_i   (ctl_div_i),
        .reload_we_i (reload_we_i),
        .reload_i    (reload_i),
        .pin_i       (pin_i),
        .count_o     (count_o),
        .sq_o        (sq_o),
        .irq_o       (irq_o)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_reload(input logic [11:0] v);
        reload_i = v; reload_we_i = 1'b1;
        cyc(1);
        reload_we_i = 1'b0;
    endtask

    task automatic set_ctl(input logic [1:0] m, input logic [3:0] d);
        ctl_mode_i = m; ctl_div_i = d; ctl_we_i = 1'b1;
        cyc(1);
        ctl_we_i = 1'b0;
    endtask

    task automatic pin_pulse(input int hi, input int lo);
        pin_i = 1'b1; cyc(hi);
        pin_i = 1'b0; cyc(lo);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // reset state and first roll-over, R1 R3 R4
        cyc(4);
        rst = 1'b0;
        check("R1 count", count_o, 12'hFFC);
        check("R1 sq", {11'd0, sq_o}, 12'd0);
        check("R1 irq", {11'd0, irq_o}, 12'd0);
        cyc(3);
        check("R4 count", count_o, 12'hFFF);
        check("R3 irq low before roll", {11'd0, irq_o}, 12'd0);
        cyc(1);
        check("R4 wrap", count_o, 12'h000);
        check("R3 irq", {11'd0, irq_o}, 12'd1);
        cyc(1);
        check("R3 irq one cycle", {11'd0, irq_o}, 12'd0);

        // vector table
        foreach (VECS[i]) begin
            set_reload(VECS[i].reload);
            set_ctl(VECS[i].mode, VECS[i].div);
            cyc(int'(VECS[i].ncyc));
            check($sformatf("R2/R4/R8 vec%0d count", i), count_o, VECS[i].exp_cnt);
            check($sformatf("R8 vec%0d sq", i), {11'd0, sq_o}, {11'd0, VECS[i].exp_sq});
        end

        // R2 clamp of divider above 12
        set_reload(12'h123);
        set_ctl(2'd0, 4'd15);
        cyc(4095);
        check("R2 clamp before", count_o, 12'h123);
        cyc(1);
        check("R2 clamp tick", count_o, 12'h124);

        // R2 reload write alone does not disturb count
        set_reload(12'h200);
        set_ctl(2'd0, 4'd0);
        cyc(3);
        check("R2 running", count_o, 12'h203);
        set_reload(12'hABC);
        check("R2 reload write only", count_o, 12'h204);

        // R5 event counting with slow divider, R6 glitch rejection
        set_reload(12'h000);
        set_ctl(2'd1, 4'd12);
        for (int k = 0; k < 5; k++) pin_pulse(3, 3);
        cyc(6);
        check("R5 events", count_o, 12'd5);
        pin_pulse(1, 8);
        check("R6 glitch ignored", count_o, 12'd5);

        // R7 pulse width measurement and freeze
        set_reload(12'h000);
        set_ctl(2'd2, 4'd0);
        cyc(2);
        pin_pulse(20, 10);
        check("R7 width", count_o, 12'd20);
        pin_pulse(5, 10);
        check("R7 frozen", count_o, 12'd20);

        // R9 wake restore from square mode
        set_reload(12'hFF0);
        set_ctl(2'd3, 4'd0);
        cyc(20);
        check("R8 pre-wake sq", {11'd0, sq_o}, 12'd1);
        wake_i = 1'b1;
        cyc(1);
        wake_i = 1'b0;
        check("R9 wake count", count_o, 12'hFFC);
        check("R9 wake keeps sq", {11'd0, sq_o}, 12'd1);
        cyc(4);
        check("R9 reload kept", count_o, 12'hFF0);
        check("R9 sq toggled", {11'd0, sq_o}, 12'd0);
        check("R3 irq after wake roll", {11'd0, irq_o}, 12'd1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule